// File: doc/BRIEF.md
# Iterative Taylor-Series Approximate Divider

This block divides two unsigned integers approximately, taking as many clock cycles as the caller asks for. Each operand has its leading zeros removed, which gives a mantissa in [0.5, 1). The quotient is the dividend mantissa multiplied by an approximate reciprocal of the divisor mantissa. That reciprocal is the partial sum 1 + x + x² + … with x = 1 − b. Each cycle adds one more power of x, and each power comes from the previous power through a multiplier that truncates its result. The caller passes an order `t` with each request, so it can trade latency against accuracy on every operation. Small orders return quickly with a coarse quotient. Larger orders approach the exact quotient from below. Any order above the operand width is cut back to the width.

The result is a fixed-point quotient with W integer bits and W fraction bits. The final multiply produces a mantissa, and a barrel shifter places it using the difference between the leading-one positions of the two operands. A zero dividend, or a zero divisor, finishes one cycle after the request without running the series.

Top module: `apx_taylor_div`

The controller has three states. `ST_IDLE` waits for `start`. `ST_SERIES` adds one series term per cycle. `ST_PRODUCT` forms and places the quotient. The transitions are:
- IDLE→SERIES when an accepted request has non-zero operands and an order greater than zero.
- IDLE→PRODUCT when an accepted request has non-zero operands and order zero.
- SERIES→SERIES while more than one term remains.
- SERIES→PRODUCT on the last term.
- PRODUCT→IDLE always.
- IDLE→IDLE on a zero operand, which raises `done` directly.

## Requirements
- R1: While `rst_n` is low, and after it rises, `done` is 0 and `quotient` is 0 until the first completed request.
- R2: Each non-zero operand is shifted left until its bit W−1 is set, giving the mantissa (value m/2^W). The series variable is x = 2^W − b_mant, kept in W bits.
- R3: The reciprocal accumulator starts at 2^W (value 1.0), and the first term is x. Each series cycle adds the current term to the accumulator, then replaces the term with floor(term·x / 2^W).
- R4: The quotient mantissa is floor(a_mant·acc / 2^(W+1)), a W-bit value with W−1 fraction bits. This mantissa is shifted left by pa − pb + 1, or right (truncating) when that amount is negative, where pa and pb are the leading-one bit indices of the dividend and divisor. The `quotient` output is the real quotient times 2^W. With W=8, 190/11 at order 1 gives 3968 (15.5).
- R5: For a request with non-zero operands sampled at clock edge k, `done` is high for exactly the one cycle after edge k+t+1, where t is the clamped order, and `quotient` updates at that same edge.
- R6: An order greater than W is treated as W, both for latency and for the result.
- R7: A zero dividend with a non-zero divisor gives `quotient` 0, with `done` high in the cycle after edge k.
- R8: A zero divisor gives `quotient` all ones, with `done` high in the cycle after edge k, whatever the dividend is.
- R9: `start` is ignored from the edge that accepts a request up to and including the edge that raises its `done`. A new request is accepted on the next edge.
- R10: Outside a completion, `done` is 0 and `quotient` keeps its last value.
- R11: For a non-zero divisor, `quotient` never exceeds floor(A·2^W / B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled while idle |
| dividend | input | W | Unsigned dividend A |
| divisor | input | W | Unsigned divisor B |
| order | input | $clog2(W+1) | Number of series terms after the constant term |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 2W | Quotient, W integer bits and W fraction bits |

## Verification
For a request accepted at edge k, the result is due after edge k+t+1 (t clamped to W) when both operands are non-zero, and after edge k when either operand is zero. The bench's reference model counts these edges itself. On every falling edge it compares both `done` and `quotient` against what the model says is due in that exact cycle, so an early, late, missing or repeated pulse is caught as well as a wrong value. Requests sent while a division is running are modelled as having no effect, so a design that accepted them would show a mismatch on the next compare.

// File: rtl/apx_div_pkg.sv
package apx_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SERIES  = 2'd1,
        ST_PRODUCT = 2'd2
    } apx_state_e;

endpackage

// File: rtl/apx_lead_one.sv
module apx_lead_one #(
    parameter  int W  = 8,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    output logic [PW-1:0] pos,
    output logic          none
);

    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (val[i]) pos = PW'(i);
        end
    end

    assign none = ~|val;

endmodule

// File: rtl/apx_series_unit.sv
module apx_series_unit #(
    parameter  int W   = 8,
    localparam int TPW = 2 * W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] x_in,
    output logic [W:0]   acc,
    output logic [W-1:0] term
);

    logic [W-1:0]   x_q;
    logic [TPW-1:0] tprod;
    logic [W-1:0]   term_next;

    assign tprod     = TPW'(term) * TPW'(x_q);
    assign term_next = W'(tprod >> W);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            term <= '0;
            x_q  <= '0;
        end else if (load) begin
            acc  <= (W+1)'(1) << W;
            term <= x_in;
            x_q  <= x_in;
        end else if (step) begin
            acc  <= acc + (W+1)'(term);
            term <= term_next;
        end
    end

    // R3
    term_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |=> term <= $past(term));

    // R3
    acc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !load |=> acc >= $past(acc));

endmodule

// File: rtl/apx_quot_place.sv
module apx_quot_place #(
    parameter  int W   = 8,
    localparam int LW  = $clog2(2 * W - 1),
    localparam int PRW = 2 * W + 1,
    localparam int XW  = 3 * W
) (
    input  logic [W-1:0]    mant_a,
    input  logic [W:0]      acc,
    input  logic [LW-1:0]   amt,
    output logic [2*W-1:0]  q
);

    logic [PRW-1:0] prod;
    logic [W-1:0]   qm;
    logic [XW-1:0]  stg [LW+1];

    assign prod   = PRW'(mant_a) * PRW'(acc);
    assign qm     = W'(prod >> (W + 1));
    assign stg[0] = XW'(qm);

    for (genvar k = 0; k < LW; k++) begin : g_shift
        assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
    end

    assign q = (2*W)'(stg[LW] >> (W - 2));

endmodule

// File: rtl/apx_taylor_div.sv
module apx_taylor_div
    import apx_div_pkg::*;
#(
    parameter  int W  = 8,
    localparam int TW = $clog2(W + 1),
    localparam int PW = $clog2(W),
    localparam int LW = $clog2(2 * W - 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   dividend,
    input  logic [W-1:0]   divisor,
    input  logic [TW-1:0]  order,
    output logic           done,
    output logic [2*W-1:0] quotient
);

    apx_state_e     state;
    logic [PW-1:0]  pa, pb;
    logic           a_zero, b_zero;
    logic [PW-1:0]  sa, sb;
    logic [W-1:0]   a_norm, b_norm, x_new;
    logic [LW-1:0]  lsh_new;
    logic [TW-1:0]  t_eff;
    logic           accept, go;

    logic [W-1:0]   mant_a;
    logic [LW-1:0]  lsh;
    logic [TW-1:0]  cnt;
    logic [W:0]     acc;
    logic [W-1:0]   term;
    logic [2*W-1:0] q_placed;

    apx_lead_one #(.W(W)) u_lead_a (.val(dividend), .pos(pa), .none(a_zero));
    apx_lead_one #(.W(W)) u_lead_b (.val(divisor),  .pos(pb), .none(b_zero));

    assign sa      = PW'(W - 1) - pa;
    assign sb      = PW'(W - 1) - pb;
    assign a_norm  = dividend << sa;
    assign b_norm  = divisor << sb;
    assign x_new   = (~b_norm) + W'(1);
    assign lsh_new = LW'(pa) + LW'(sb);
    assign t_eff   = (order > TW'(W)) ? TW'(W) : order;
    assign accept  = (state == ST_IDLE) && start;
    assign go      = accept && !a_zero && !b_zero;

    apx_series_unit #(.W(W)) u_series (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go),
        .step  (state == ST_SERIES),
        .x_in  (x_new),
        .acc   (acc),
        .term  (term)
    );

    apx_quot_place #(.W(W)) u_place (
        .mant_a (mant_a),
        .acc    (acc),
        .amt    (lsh),
        .q      (q_placed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    if (go) state <= (t_eff == '0) ? ST_PRODUCT : ST_SERIES;
                ST_SERIES:  if (cnt == TW'(1)) state <= ST_PRODUCT;
                ST_PRODUCT: state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            quotient <= '0;
            mant_a   <= '0;
            lsh      <= '0;
            cnt      <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (b_zero) begin
                            done     <= 1'b1;
                            quotient <= '1;
                        end else if (a_zero) begin
                            done     <= 1'b1;
                            quotient <= '0;
                        end else begin
                            mant_a <= a_norm;
                            lsh    <= lsh_new;
                            cnt    <= t_eff;
                        end
                    end
                end
                ST_SERIES: cnt <= cnt - TW'(1);
                ST_PRODUCT: begin
                    done     <= 1'b1;
                    quotient <= q_placed;
                end
                default: ;
            endcase
        end
    end

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state == ST_IDLE);

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IDLE |=> $stable(mant_a) && $stable(lsh));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SERIES |-> (cnt != '0) && (cnt <= TW'(W)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(quotient));

endmodule

// File: tb/tb_apx_taylor_div.sv
`timescale 1ns/1ps
module tb_apx_taylor_div;

    localparam int W  = 8;
    localparam int TW = $clog2(W + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   dividend = '0;
    logic [W-1:0]   divisor = '0;
    logic [TW-1:0]  order = '0;
    logic           done;
    logic [2*W-1:0] quotient;

    int    n_checks = 0;
    int    n_fails  = 0;
    string in_tag   = "R4";

    apx_taylor_div #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .order(order), .done(done), .quotient(quotient)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act,
                         input longint exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    function automatic longint ref_q(input int a, input int b, input int t);
        int pa = 0, pb = 0, tc, sh;
        longint an, bn, x, acc, term, qm;
        if (b == 0) return (longint'(1) << (2 * W)) - 1;
        if (a == 0) return 0;
        tc = (t > W) ? W : t;
        for (int i = 0; i < W; i++) begin
            if ((a >> i) & 1) pa = i;
            if ((b >> i) & 1) pb = i;
        end
        an   = longint'(a) << (W - 1 - pa);
        bn   = longint'(b) << (W - 1 - pb);
        x    = (longint'(1) << W) - bn;
        acc  = longint'(1) << W;
        term = x;
        for (int i = 0; i < tc; i++) begin
            acc  = acc + term;
            term = (term * x) >> W;
        end
        qm = (an * acc) >> (W + 1);
        sh = pa - pb + 1;
        return (sh >= 0) ? (qm << sh) : (qm >> (-sh));
    endfunction

    // behavioural reference: cycles left, pending result, expected outputs
    int     m_left = 0;
    longint m_res = 0;
    string  m_tag = "R4";
    int     m_a = 0, m_b = 0;
    bit     exp_done = 1'b0;
    longint exp_q = 0;
    string  done_tag = "R4";
    int     done_a = 0, done_b = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; exp_done = 1'b0; exp_q = 0;
        end else begin
            exp_done = 1'b0;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    exp_done = 1'b1; exp_q = m_res;
                    done_tag = m_tag; done_a = m_a; done_b = m_b;
                end
            end else if (start) begin
                m_a   = int'(dividend);
                m_b   = int'(divisor);
                m_tag = in_tag;
                m_res = ref_q(m_a, m_b, int'(order));
                if (m_a == 0 || m_b == 0) begin
                    exp_done = 1'b1; exp_q = m_res;
                    done_tag = m_tag; done_a = m_a; done_b = m_b;
                end else begin
                    m_left = ((int'(order) > W) ? W : int'(order)) + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(done == exp_done, exp_done ? "R5" : "R10", longint'(done),
                  longint'(exp_done), "done");
            check(longint'(quotient) == exp_q, exp_done ? done_tag : "R10",
                  longint'(quotient), exp_q, "quotient");
            if (exp_done && done_b != 0)
                check(longint'(quotient) <= ((longint'(done_a) << W) / done_b), "R11",
                      longint'(quotient), (longint'(done_a) << W) / done_b, "upper bound");
        end
    end

    task automatic pulse(input int a, input int b, input int t, input string tag);
        @(negedge clk);
        dividend = W'(a); divisor = W'(b); order = TW'(t); in_tag = tag; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input int a, input int b, input int t, input string tag);
        pulse(a, b, t, tag);
        repeat (W + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        check(done == 1'b0, "R1", longint'(done), 0, "done in reset");
        check(quotient == '0, "R1", longint'(quotient), 0, "quotient in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(quotient == '0, "R1", longint'(quotient), 0, "quotient after reset");

        run(190, 11, 1, "R4");
        check(quotient == 16'd3968, "R4", longint'(quotient), 3968, "190/11 order 1");
        run(190, 11, 0, "R3");
        run(190, 11, 2, "R3");
        run(190, 11, 8, "R3");
        run(190, 11, 15, "R6");
        run(200, 64, 4, "R2");
        run(1, 255, 8, "R2");
        run(255, 1, 8, "R4");
        run(128, 128, 3, "R4");
        run(0, 5, 6, "R7");
        run(7, 0, 6, "R8");
        run(0, 0, 2, "R8");

        // R9: second strobe while the first division runs
        pulse(190, 11, 8, "R9");
        repeat (2) @(negedge clk);
        pulse(3, 200, 1, "R9");
        repeat (W + 2) @(negedge clk);

        // back-to-back: next strobe on the first idle edge
        pulse(100, 7, 2, "R5");
        repeat (2) @(negedge clk);
        pulse(0, 9, 0, "R7");
        pulse(77, 3, 0, "R5");
        repeat (W + 2) @(negedge clk);

        for (int i = 0; i < 300; i++) begin
            int a, b, t;
            a = int'($urandom_range(0, (1 << W) - 1));
            b = int'($urandom_range(0, (1 << W) - 1));
            t = int'($urandom_range(0, (1 << TW) - 1));
            if (i % 37 == 0) b = 0;
            run(a, b, t, (t > W) ? "R6" : "R4");
        end

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule